// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a synchronous DRAM from the controller side. On every rising clock edge it takes in chip select, the three strobe lines, clock enable, the address bus and the bank address. It turns that pattern into a named command and keeps a small state machine for each bank. Each bank is idle, open with a recorded row, or open with an automatic close scheduled at the end of its burst. A mode-set command loads the burst and latency fields. The block can serve as a bus protocol checker or as the command front end of a memory model. It holds no data.

Every command is checked against the bank and mode state held just before the edge. A command that breaks a rule raises a violation flag with a code for one cycle. It changes nothing, so the state stays at the last legal one. The decoded command, the flag and all state outputs are registered. They show the effect of the edge at which the command was sampled.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: One clock edge after sampling, `cmd_o` shows the decoded command. With chip select high it shows 0 (deselect). With chip select low, the strobes {ras_n,cas_n,we_n} decode as follows. 011 gives 2 (activate). 101 gives 3 (read), or 4 when addr[10] is high. 100 gives 5 (write), or 6 when addr[10] is high. 010 gives 7 (precharge one bank), or 8 (precharge all) when addr[10] is high. 000 gives 9 (mode set). 001 gives 10 (auto refresh) with cke high and 11 (self refresh entry) with cke low. 110 gives 12 (burst stop). 111 gives 1 (no operation).
- R2: An activate to an idle bank opens it and records addr as its open row. `bank_state_o[2b+1:2b]` reads 1 and the row appears in `open_row_o`. An activate to a bank that is not idle raises code 7.
- R3: Precharge with addr[10] low closes only the bank named by `ba`. Precharge with addr[10] high closes every bank. Closed banks read state 0.
- R4: A read or write with addr[10] high, made to an open bank, moves that bank to state 2. The bank returns to state 0 a number of clock edges after the command edge equal to the burst length. The burst length is 1, 2, 4 or 8 for codes 0 to 3, and PAGE_LEN for code 7.
- R5: A read or write to an idle bank raises code 4.
- R6: A read or write to a bank fewer than TRCD clock edges after that bank's activate raises code 5. Priority for reads and writes is code 4 first, then code 6, then code 5.
- R7: A precharge (single or all), a burst stop, or a read or write that reaches a bank in state 2 raises code 6.
- R8: A legal mode set stores addr[2:0] as `burst_len_o`, addr[3] as `burst_ilv_o`, addr[5:4] as `cas_lat_o` and addr[9] as `single_wr_o`, and sets `mode_valid_o`.
- R9: A mode set raises code 1 while any bank is not idle. Otherwise it raises code 2 if cke was low at the previous clock edge.
- R10: If neither code 1 nor code 2 applies, a mode set with a reserved value raises code 3 and leaves all mode outputs unchanged. The reserved values are burst code 4, 5 or 6, a latency field addr[6:4] other than 2 or 3, or addr[8:7] non-zero.
- R11: After reset, all banks are idle, `mode_valid_o` and all mode fields are 0, `cmd_o` is 0 and no violation is flagged.
- R12: A deselected edge changes no bank or mode state and raises no violation. Burst timers already running keep counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | $clog2(NBANK) | Bank address |
| addr | input | ROW_W | Address bus; bit 10 qualifies precharge and reads/writes |
| cmd_o | output | 4 | Decoded command code |
| bank_state_o | output | 2*NBANK | Per-bank state: 0 idle, 1 open, 2 close pending |
| open_row_o | output | NBANK*ROW_W | Open row of each bank |
| mode_valid_o | output | 1 | A legal mode set has occurred |
| burst_len_o | output | 3 | Burst length code |
| burst_ilv_o | output | 1 | Interleaved burst order selected |
| cas_lat_o | output | 2 | Read latency in clocks |
| single_wr_o | output | 1 | Single-beat write mode selected |
| viol_o | output | 1 | Command at previous edge was illegal |
| viol_code_o | output | 3 | Violation code, 0 when none |

## Verification
The bench first goes after the timing edges. It issues a read exactly one edge before the row-to-column window closes and then exactly on it. If a counter were off by one, the early read would be accepted or the on-time read would be flagged. It then aims a precharge, a burst stop and a same-bank read at a bank with a pending automatic close. It lets that close finish while chip select is high. A design that applied the rejected command, or froze its timers on deselect, would show a bank idle too early or one that never closes. It also tests a mode set right after reset, a full-page close pending for PAGE_LEN clocks, and a single-bank precharge beside open neighbours. These catch a stale clock-enable register, a wrong page count and an address qualifier that is ignored.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_RDA   = 4'd4,
        CMD_WR    = 4'd5,
        CMD_WRA   = 4'd6,
        CMD_PRE   = 4'd7,
        CMD_PREA  = 4'd8,
        CMD_MRS   = 4'd9,
        CMD_AREF  = 4'd10,
        CMD_SREF  = 4'd11,
        CMD_BST   = 4'd12
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_AUTOPRE = 2'd2
    } bank_st_e;

    typedef enum logic [2:0] {
        V_NONE      = 3'd0,
        V_MRS_BUSY  = 3'd1,
        V_MRS_CKE   = 3'd2,
        V_MODE_RSVD = 3'd3,
        V_RW_IDLE   = 3'd4,
        V_RW_EARLY  = 3'd5,
        V_AP_HIT    = 3'd6,
        V_ACT_OPEN  = 3'd7
    } viol_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic ap,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_DESEL;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = ap ? CMD_RDA : CMD_RD;
                3'b100:  cmd = ap ? CMD_WRA : CMD_WR;
                3'b010:  cmd = ap ? CMD_PREA : CMD_PRE;
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [9:0] bits_in,
    output logic       rsvd,
    output logic       valid,
    output logic [2:0] bl_code,
    output logic       ilv,
    output logic [1:0] cl,
    output logic       single_wr
);

    logic [2:0] bl_field;
    logic [2:0] cl_field;

    always_comb begin
        bl_field = bits_in[2:0];
        cl_field = bits_in[6:4];
        rsvd = (bl_field inside {3'd4, 3'd5, 3'd6})
            || !(cl_field inside {3'd2, 3'd3})
            || (bits_in[8:7] != 2'b00);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid     <= 1'b0;
            bl_code   <= 3'd0;
            ilv       <= 1'b0;
            cl        <= 2'd0;
            single_wr <= 1'b0;
        end else if (load) begin
            valid     <= 1'b1;
            bl_code   <= bits_in[2:0];
            ilv       <= bits_in[3];
            cl        <= bits_in[5:4];
            single_wr <= bits_in[9];
        end
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_mon_pkg::*;
#(
    parameter int ROW_W    = 13,
    parameter int TRCD     = 3,
    parameter int PAGE_LEN = 512
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              act,
    input  logic                              close,
    input  logic                              rw_ap,
    input  logic [ROW_W-1:0]                  row_in,
    input  logic [$clog2(PAGE_LEN+1)-1:0]     blen,
    output bank_st_e                          state,
    output logic [ROW_W-1:0]                  row,
    output logic                              rcd_ok
);

    localparam int AP_W  = $clog2(PAGE_LEN + 1);
    localparam int RCD_W = (TRCD > 1) ? $clog2(TRCD) : 1;

    bank_st_e          st_q, st_d;
    logic [ROW_W-1:0]  row_q, row_d;
    logic [RCD_W-1:0]  rcd_q, rcd_d;
    logic [AP_W-1:0]   apc_q, apc_d;

    // next-state: IDLE -activate-> OPEN; OPEN -precharge-> IDLE;
    // OPEN -read/write with close-> AUTOPRE; AUTOPRE -burst done-> IDLE
    always_comb begin
        st_d  = st_q;
        row_d = row_q;
        apc_d = apc_q;
        rcd_d = (rcd_q != '0) ? rcd_q - RCD_W'(1) : rcd_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act) begin
                    st_d  = BK_OPEN;
                    row_d = row_in;
                    rcd_d = RCD_W'(TRCD - 1);
                end
            end
            BK_OPEN: begin
                if (close) begin
                    st_d = BK_IDLE;
                end else if (rw_ap) begin
                    st_d  = BK_AUTOPRE;
                    apc_d = blen;
                end
            end
            BK_AUTOPRE: begin
                if (apc_q <= AP_W'(1)) begin
                    st_d  = BK_IDLE;
                    apc_d = '0;
                end else begin
                    apc_d = apc_q - AP_W'(1);
                end
            end
            default: st_d = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            row_q <= '0;
            rcd_q <= '0;
            apc_q <= '0;
        end else begin
            st_q  <= st_d;
            row_q <= row_d;
            rcd_q <= rcd_d;
            apc_q <= apc_d;
        end
    end

    always_comb begin
        state  = st_q;
        row    = row_q;
        rcd_ok = (rcd_q == '0);
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int ROW_W    = 13,
    parameter int TRCD     = 3,
    parameter int PAGE_LEN = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     we_n,
    input  logic                     cke,
    input  logic [$clog2(NBANK)-1:0] ba,
    input  logic [ROW_W-1:0]         addr,
    output logic [3:0]               cmd_o,
    output logic [2*NBANK-1:0]       bank_state_o,
    output logic [NBANK*ROW_W-1:0]   open_row_o,
    output logic                     mode_valid_o,
    output logic [2:0]               burst_len_o,
    output logic                     burst_ilv_o,
    output logic [1:0]               cas_lat_o,
    output logic                     single_wr_o,
    output logic                     viol_o,
    output logic [2:0]               viol_code_o
);

    localparam int BA_W   = $clog2(NBANK);
    localparam int AP_W   = $clog2(PAGE_LEN + 1);
    localparam int AP_BIT = 10;

    cmd_e             cmd_now, cmd_q;
    viol_e            code, code_q;
    logic             viol_q;
    logic             cke_q;
    logic             mode_rsvd;
    logic             mode_load;
    logic [AP_W-1:0]  blen;
    logic             any_busy, any_ap;
    logic             ok;

    bank_st_e         bst    [NBANK];
    logic [ROW_W-1:0] brow   [NBANK];
    logic             rcd_ok [NBANK];
    logic [NBANK-1:0] act_v, close_v, rwap_v;

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .ap    (addr[AP_BIT]),
        .cmd   (cmd_now)
    );

    sdram_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mode_load),
        .bits_in   (addr[9:0]),
        .rsvd      (mode_rsvd),
        .valid     (mode_valid_o),
        .bl_code   (burst_len_o),
        .ilv       (burst_ilv_o),
        .cl        (cas_lat_o),
        .single_wr (single_wr_o)
    );

    always_comb begin
        unique case (burst_len_o)
            3'd0:    blen = AP_W'(1);
            3'd1:    blen = AP_W'(2);
            3'd2:    blen = AP_W'(4);
            3'd3:    blen = AP_W'(8);
            3'd7:    blen = AP_W'(PAGE_LEN);
            default: blen = AP_W'(1);
        endcase
    end

    always_comb begin
        any_busy = 1'b0;
        any_ap   = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            if (bst[b] != BK_IDLE)    any_busy = 1'b1;
            if (bst[b] == BK_AUTOPRE) any_ap   = 1'b1;
        end
    end

    // legality against the state held before this edge
    always_comb begin
        code = V_NONE;
        unique case (cmd_now)
            CMD_ACT: begin
                if (bst[ba] != BK_IDLE) code = V_ACT_OPEN;
            end
            CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
                if (bst[ba] == BK_IDLE)         code = V_RW_IDLE;
                else if (bst[ba] == BK_AUTOPRE) code = V_AP_HIT;
                else if (!rcd_ok[ba])           code = V_RW_EARLY;
            end
            CMD_PRE: begin
                if (bst[ba] == BK_AUTOPRE) code = V_AP_HIT;
            end
            CMD_PREA, CMD_BST: begin
                if (any_ap) code = V_AP_HIT;
            end
            CMD_MRS: begin
                if (any_busy)       code = V_MRS_BUSY;
                else if (!cke_q)    code = V_MRS_CKE;
                else if (mode_rsvd) code = V_MODE_RSVD;
            end
            default: code = V_NONE;
        endcase
    end

    always_comb begin
        ok        = (code == V_NONE);
        mode_load = ok && (cmd_now == CMD_MRS);
        for (int b = 0; b < NBANK; b++) begin
            act_v[b]   = ok && (cmd_now == CMD_ACT) && (ba == BA_W'(b));
            close_v[b] = ok && (((cmd_now == CMD_PRE) && (ba == BA_W'(b)))
                                || (cmd_now == CMD_PREA));
            rwap_v[b]  = ok && ((cmd_now == CMD_RDA) || (cmd_now == CMD_WRA))
                            && (ba == BA_W'(b));
        end
    end

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            sdram_bank_fsm #(
                .ROW_W    (ROW_W),
                .TRCD     (TRCD),
                .PAGE_LEN (PAGE_LEN)
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .act    (act_v[g]),
                .close  (close_v[g]),
                .rw_ap  (rwap_v[g]),
                .row_in (addr),
                .blen   (blen),
                .state  (bst[g]),
                .row    (brow[g]),
                .rcd_ok (rcd_ok[g])
            );
            assign bank_state_o[2*g +: 2]     = bst[g];
            assign open_row_o[g*ROW_W +: ROW_W] = brow[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_DESEL;
            code_q <= V_NONE;
            viol_q <= 1'b0;
            cke_q  <= 1'b0;
        end else begin
            cmd_q  <= cmd_now;
            code_q <= code;
            viol_q <= (code != V_NONE);
            cke_q  <= cke;
        end
    end

    always_comb begin
        cmd_o       = cmd_q;
        viol_o      = viol_q;
        viol_code_o = code_q;
    end

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
    parameter int NBANK = 4,
    parameter int ROW_W = 13
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic [3:0]               cmd_o,
    input logic [2*NBANK-1:0]       bank_state_o,
    input logic                     mode_valid_o,
    input logic [2:0]               burst_len_o,
    input logic                     burst_ilv_o,
    input logic [1:0]               cas_lat_o,
    input logic                     single_wr_o,
    input logic                     viol_o,
    input logic [2:0]               viol_code_o
);

    a_r1_deselect_decodes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> cmd_o == 4'd0);

    a_r12_viol_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $past(!cs_n));

    a_r3_prea_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd8 && !viol_o) |-> bank_state_o == '0);

    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_valid_o) |-> mode_valid_o);

    a_r10_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o && viol_code_o inside {3'd1, 3'd2, 3'd3})
        |-> $stable({mode_valid_o, burst_len_o, burst_ilv_o, cas_lat_o, single_wr_o}));

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank_chk
            a_r4_autopre_from_open: assert property (@(posedge clk) disable iff (!rst_n)
                (bank_state_o[2*g +: 2] == 2'd2 && $past(bank_state_o[2*g +: 2]) != 2'd2)
                |-> $past(bank_state_o[2*g +: 2]) == 2'd1);

            a_r2_open_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
                (bank_state_o[2*g +: 2] == 2'd1 && $past(bank_state_o[2*g +: 2]) == 2'd0)
                |-> (cmd_o == 4'd2 && !viol_o));
        end
    endgenerate

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
    .NBANK (NBANK),
    .ROW_W (ROW_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .cmd_o        (cmd_o),
    .bank_state_o (bank_state_o),
    .mode_valid_o (mode_valid_o),
    .burst_len_o  (burst_len_o),
    .burst_ilv_o  (burst_ilv_o),
    .cas_lat_o    (cas_lat_o),
    .single_wr_o  (single_wr_o),
    .viol_o       (viol_o),
    .viol_code_o  (viol_code_o)
);

// File: tb/sdram_cmd_monitor_tb.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb;

    localparam int NB   = 4;
    localparam int RW   = 13;
    localparam int TRCD = 3;
    localparam int PAGE = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0]    ba = '0;
    logic [RW-1:0] addr = '0;
    logic [3:0]    cmd_o;
    logic [2*NB-1:0]  bank_state_o;
    logic [NB*RW-1:0] open_row_o;
    logic          mode_valid_o, burst_ilv_o, single_wr_o, viol_o;
    logic [2:0]    burst_len_o, viol_code_o;
    logic [1:0]    cas_lat_o;

    always #4 clk = ~clk;

    sdram_cmd_monitor #(.NBANK(NB), .ROW_W(RW), .TRCD(TRCD), .PAGE_LEN(PAGE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_o(cmd_o),
        .bank_state_o(bank_state_o), .open_row_o(open_row_o),
        .mode_valid_o(mode_valid_o), .burst_len_o(burst_len_o),
        .burst_ilv_o(burst_ilv_o), .cas_lat_o(cas_lat_o),
        .single_wr_o(single_wr_o), .viol_o(viol_o), .viol_code_o(viol_code_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // reference model of the requirements
    int          m_state [NB];
    logic [RW-1:0] m_row [NB];
    int          m_rcd   [NB];
    int          m_ap    [NB];
    bit          m_cke_q;
    bit          m_valid;
    bit [2:0]    m_bl;
    bit          m_bt;
    bit [1:0]    m_cl;
    bit          m_sw;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int f_decode(bit c, bit r, bit a, bit w, bit k, bit ap);
        if (c) return 0;
        case ({r, a, w})
            3'b011: return 2;
            3'b101: return ap ? 4 : 3;
            3'b100: return ap ? 6 : 5;
            3'b010: return ap ? 8 : 7;
            3'b000: return 9;
            3'b001: return k ? 10 : 11;
            3'b110: return 12;
            default: return 1;
        endcase
    endfunction

    function automatic int f_blen();
        case (m_bl)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return PAGE;
            default: return 1;
        endcase
    endfunction

    function automatic bit f_rsvd(bit [9:0] mb);
        return (mb[2:0] inside {3'd4, 3'd5, 3'd6}) || !(mb[6:4] inside {3'd2, 3'd3})
            || (mb[8:7] != 2'b00);
    endfunction

    function automatic int f_code(int c, int b, bit [9:0] mb);
        bit busy = 0, apx = 0;
        for (int i = 0; i < NB; i++) begin
            if (m_state[i] != 0) busy = 1;
            if (m_state[i] == 2) apx = 1;
        end
        case (c)
            2: return (m_state[b] != 0) ? 7 : 0;
            3, 4, 5, 6: begin
                if (m_state[b] == 0) return 4;
                if (m_state[b] == 2) return 6;
                if (m_rcd[b] != 0)   return 5;
                return 0;
            end
            7: return (m_state[b] == 2) ? 6 : 0;
            8, 12: return apx ? 6 : 0;
            9: begin
                if (busy)     return 1;
                if (!m_cke_q) return 2;
                if (f_rsvd(mb)) return 3;
                return 0;
            end
            default: return 0;
        endcase
    endfunction

    function automatic string vtag(int v);
        case (v)
            1, 2: return "R9";
            3: return "R10";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            7: return "R2";
            default: return "R1";
        endcase
    endfunction

    function automatic string btag(int c);
        case (c)
            0: return "R12";
            2: return "R2";
            7, 8: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic issue(input bit c, input bit r, input bit a, input bit w, input bit k,
                         input int b, input logic [RW-1:0] ad);
        int ec, vc;
        logic [2*NB-1:0] exp_bs;
        bit rows_ok;
        cs_n = c; ras_n = r; cas_n = a; we_n = w; cke = k;
        ba = b[1:0]; addr = ad;
        ec = f_decode(c, r, a, w, k, ad[10]);
        vc = f_code(ec, b, ad[9:0]);
        @(posedge clk);
        @(negedge clk);
        // timers advance every edge
        for (int i = 0; i < NB; i++) begin
            if (m_rcd[i] > 0) m_rcd[i]--;
            if (m_state[i] == 2) begin
                if (m_ap[i] <= 1) begin m_state[i] = 0; m_ap[i] = 0; end
                else m_ap[i]--;
            end
        end
        if (vc == 0) begin
            case (ec)
                2: begin m_state[b] = 1; m_row[b] = ad; m_rcd[b] = TRCD - 1; end
                4, 6: begin m_state[b] = 2; m_ap[b] = f_blen(); end
                7: m_state[b] = 0;
                8: for (int i = 0; i < NB; i++) m_state[i] = 0;
                9: begin
                    m_valid = 1; m_bl = ad[2:0]; m_bt = ad[3]; m_cl = ad[5:4]; m_sw = ad[9];
                end
                default: ;
            endcase
        end
        m_cke_q = k;
        check(cmd_o == ec[3:0], "R1", "command", cmd_o, ec);
        check(viol_o == (vc != 0) && viol_code_o == vc[2:0], vtag(vc), "violation",
              {viol_o, viol_code_o}, {(vc != 0), vc[2:0]});
        rows_ok = 1;
        for (int i = 0; i < NB; i++) begin
            exp_bs[2*i +: 2] = m_state[i][1:0];
            if (m_state[i] != 0 && open_row_o[i*RW +: RW] != m_row[i]) rows_ok = 0;
        end
        check(bank_state_o == exp_bs, btag(ec), "bank state", bank_state_o, exp_bs);
        check(rows_ok, "R2", "open rows", open_row_o, 0);
        check({mode_valid_o, burst_len_o, burst_ilv_o, cas_lat_o, single_wr_o}
              == {m_valid, m_bl, m_bt, m_cl, m_sw},
              (ec == 9 && vc == 3) ? "R10" : "R8", "mode",
              {mode_valid_o, burst_len_o, burst_ilv_o, cas_lat_o, single_wr_o},
              {m_valid, m_bl, m_bt, m_cl, m_sw});
    endtask

    task automatic nop();                       issue(0,1,1,1,1,0,'0); endtask
    task automatic act(int b, logic [RW-1:0] r); issue(0,0,1,1,1,b,r); endtask
    task automatic rd(int b, bit ap);           issue(0,1,0,1,1,b,{2'b00, ap, 10'h015}); endtask
    task automatic wr(int b, bit ap);           issue(0,1,0,0,1,b,{2'b00, ap, 10'h02A}); endtask
    task automatic pre(int b);                  issue(0,0,1,0,1,b,'0); endtask
    task automatic prea();                      issue(0,0,1,0,1,0,13'h0400); endtask
    task automatic mrs(bit [9:0] mb);           issue(0,0,0,0,1,0,{3'b000, mb}); endtask
    task automatic bst();                       issue(0,1,1,0,1,0,'0); endtask

    task automatic rand_step();
        int op, b;
        bit c, k;
        logic [RW-1:0] ad;
        c  = ($urandom_range(0, 99) < 8);
        k  = ($urandom_range(0, 19) != 0);
        b  = $urandom_range(0, NB - 1);
        ad = RW'($urandom);
        op = $urandom_range(0, 10);
        case (op)
            0, 1, 2: issue(c,0,1,1,k,b,ad);
            3:       issue(c,1,0,1,k,b,ad);
            4:       issue(c,1,0,0,k,b,ad);
            5:       issue(c,0,1,0,k,b,ad);
            6: begin
                ad = '0;
                ad[2:0] = ($urandom_range(0, 9) == 0) ? 3'd5 : 3'($urandom_range(0, 3));
                ad[3]   = 1'($urandom);
                ad[6:4] = ($urandom_range(0, 9) == 0) ? 3'd1 : 3'($urandom_range(2, 3));
                ad[9]   = 1'($urandom);
                issue(c,0,0,0,k,b,ad);
            end
            7:       issue(c,1,1,0,k,b,ad);
            8:       issue(c,0,0,1,k,b,ad);
            default: issue(c,1,1,1,k,b,ad);
        endcase
    endtask

    initial begin
        #(8 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5D12A7);
        for (int i = 0; i < NB; i++) begin
            m_state[i] = 0; m_row[i] = '0; m_rcd[i] = 0; m_ap[i] = 0;
        end
        m_cke_q = 0; m_valid = 0; m_bl = 0; m_bt = 0; m_cl = 0; m_sw = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state seen at the outputs (no edge after release yet)
        check(cmd_o == 4'd0 && !viol_o && viol_code_o == 3'd0, "R11", "reset cmd/viol",
              {cmd_o, viol_o, viol_code_o}, 0);
        check(bank_state_o == '0, "R11", "reset banks", bank_state_o, 0);
        check({mode_valid_o, burst_len_o, burst_ilv_o, cas_lat_o, single_wr_o} == '0,
              "R11", "reset mode", {mode_valid_o, burst_len_o, burst_ilv_o, cas_lat_o, single_wr_o}, 0);

        mrs(10'h022);            // R9: clock-enable register still reset low -> code 2
        mrs(10'h022);            // R8: BL4, sequential, latency 2
        mrs(10'h012);            // R10: latency 1 reserved
        mrs(10'h025);            // R10: burst code 5 reserved
        rd(1, 0);                // R5: idle bank
        act(0, 13'h0123);
        rd(0, 0);                // R6: one edge after activate
        rd(0, 0);                // R6: TRCD-1 edges, still early
        rd(0, 0);                // R6: exactly TRCD, legal
        act(0, 13'h0456);        // R2: already open -> code 7
        act(2, 13'h1ABC);
        nop(); nop();
        wr(2, 1);                // R4: close pending, BL4
        pre(2);                  // R7
        bst();                   // R7
        rd(2, 0);                // R7: same-bank access
        nop(); nop();
        act(1, 13'h0F0F);
        mrs(10'h032);            // R9: banks open -> code 1
        pre(0);                  // R3: only bank 0 closes
        prea();                  // R3: remaining banks close
        act(3, 13'h0777);
        nop(); nop();
        rd(3, 1);
        for (int i = 0; i < 5; i++) issue(1,0,0,0,1,3,'0);  // R12: deselected, close still completes
        issue(0,0,0,1,1,0,'0);   // R1: auto refresh
        issue(0,0,0,1,0,0,'0);   // R1: self refresh entry
        nop();
        mrs(10'h027);            // R8: full page
        act(3, 13'h0101);
        nop(); nop();
        rd(3, 1);                // R4: close after PAGE edges
        for (int i = 0; i < PAGE + 2; i++) nop();
        mrs(10'h23B);            // R8: interleave, latency 3, single write, BL8
        prea();
        for (int i = 0; i < 3000; i++) begin
            if (i % 40 == 39) prea();
            else rand_step();
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule